// File: doc/BRIEF.md
# Dual-Port Address-Collision Busy Arbiter

This block sits beside a two-port memory array and watches both ports' enable and address. When both ports are enabled on the same word, it picks one port to keep the location and signals the other with an active-low busy line. The port that presented its access in an earlier clock cycle wins. A port starts a new access when its enable rises or when its address changes while enabled. If both ports start in the same cycle, the left port wins. Once a winner is chosen, it is held in a register until the collision ends, so the busy decision cannot change while the two addresses stay equal.

A mode input selects between master and slave operation, which lets several devices be placed side by side to build a wider word.

- As a master, the block computes busy itself and drives it out on its busy outputs. These outputs can then feed the busy inputs of slave devices.
- As a slave, the block ignores its own comparison and holds its busy outputs inactive. It takes busy from the external inputs instead.

In both modes a per-port write-inhibit signal tells the array to drop that port's write. Reads are never blocked.

Top module: `busy_arb`

## Requirements
- R1: In master mode a port's busy output (`busyOutLN`, `busyOutRN`) is low only if, at the previous clock edge, both enables were high and both addresses were equal.
- R2: Busy is active low, with one output per port. During reset and right after it, both busy outputs are high and both write-inhibit outputs are low.
- R3: A port starts a new access in a cycle where its enable is high and either its enable was low or its address was different at the previous edge. When a collision first appears and one port started later than the other, the later port's busy output goes low after the next clock edge.
- R4: If both ports start their accesses in the same cycle onto a collision, the right port receives busy and the left port wins. The same outcome applies when neither port counts as newly started.
- R5: Busy is released (driven high) after the first clock edge at which the addresses differ or either enable is low.
- R6: The two busy outputs are never low at the same time.
- R7: While the collision persists, the chosen winner does not change and the busy outputs stay constant.
- R8: In master mode, a port's write-inhibit output is high exactly when that port's busy output is low.
- R9: In slave mode (`masterMode` = 0), both busy outputs are held high. Each write-inhibit output follows the inverse of that port's busy input (`busyInLN`, `busyInRN`) in the same cycle, and the port's own address collision has no effect on it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| masterMode | input | 1 | 1 = master (computes busy), 0 = slave (imports busy) |
| leftEn | input | 1 | Left port enable, active high |
| leftAddr | input | ADDR_W | Left port word address |
| rightEn | input | 1 | Right port enable, active high |
| rightAddr | input | ADDR_W | Right port word address |
| busyInLN | input | 1 | Slave mode: external busy for left port, active low |
| busyInRN | input | 1 | Slave mode: external busy for right port, active low |
| busyOutLN | output | 1 | Master mode: busy to left port, active low |
| busyOutRN | output | 1 | Master mode: busy to right port, active low |
| wrInhibitL | output | 1 | Blocks left port writes to the array |
| wrInhibitR | output | 1 | Blocks right port writes to the array |

## Verification
The bench builds the arbiter with `ADDR_W` = 3 instead of the 14-bit default. With only eight words, random traffic collides often, so the bench reaches the following cases in large numbers:
- simultaneous starts;
- a loser that keeps its address while the winner holds;
- release through a dropped enable.

Directed sequences check left-first, right-first and same-cycle arrival. Further directed sequences cover release by address change and by enable drop, and a slave-mode stretch in which a live collision must not reach the outputs.

// File: rtl/busy_arb_pkg.sv
package busy_arb_pkg;
  // who currently holds the contended word
  typedef enum logic [1:0] {
    OWN_NONE  = 2'd0,
    OWN_LEFT  = 2'd1,
    OWN_RIGHT = 2'd2
  } owner_e;

  // strobes from the compare datapath to the arbitration control
  typedef struct packed {
    logic hit;
    logic leftFresh;
    logic rightFresh;
  } cmpStrobe_t;
endpackage

// File: rtl/busy_arb_cmp.sv
module busy_arb_cmp
  import busy_arb_pkg::*;
#(
  parameter int ADDR_W = 14
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              leftEn,
  input  logic [ADDR_W-1:0] leftAddr,
  input  logic              rightEn,
  input  logic [ADDR_W-1:0] rightAddr,
  output cmpStrobe_t        strobe
);
  localparam int PORTS = 2;

  logic [PORTS-1:0]             enVec;
  logic [PORTS-1:0][ADDR_W-1:0] addrVec;
  logic [PORTS-1:0]             prevEn;
  logic [PORTS-1:0][ADDR_W-1:0] prevAddr;
  logic [PORTS-1:0]             freshVec;

  assign enVec   = {rightEn, leftEn};
  assign addrVec = {rightAddr, leftAddr};

  for (genvar p = 0; p < PORTS; p++) begin : g_port
    always_ff @(posedge clk) begin
      if (!rstN) begin
        prevEn[p]   <= 1'b0;
        prevAddr[p] <= '0;
      end else begin
        prevEn[p]   <= enVec[p];
        prevAddr[p] <= addrVec[p];
      end
    end
    // a new access: enable just rose, or address moved while enabled
    assign freshVec[p] = enVec[p] && (!prevEn[p] || (addrVec[p] != prevAddr[p]));
  end

  assign strobe.hit        = leftEn && rightEn && (leftAddr == rightAddr);
  assign strobe.leftFresh  = freshVec[0];
  assign strobe.rightFresh = freshVec[1];
endmodule

// File: rtl/busy_arb_ctrl.sv
module busy_arb_ctrl
  import busy_arb_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  cmpStrobe_t strobe,
  input  logic       masterMode,
  input  logic       busyInLN,
  input  logic       busyInRN,
  output logic       busyOutLN,
  output logic       busyOutRN,
  output logic       wrInhibitL,
  output logic       wrInhibitR
);
  owner_e owner, ownerNext;
  logic   leftLoses, rightLoses;

  always_comb begin
    ownerNext = owner;
    if (!strobe.hit) begin
      ownerNext = OWN_NONE;
    end else if (owner == OWN_NONE) begin
      // the older access keeps the word; ties go to the left port
      ownerNext = (strobe.leftFresh && !strobe.rightFresh) ? OWN_RIGHT : OWN_LEFT;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) owner <= OWN_NONE;
    else       owner <= ownerNext;
  end

  assign leftLoses  = (owner == OWN_RIGHT);
  assign rightLoses = (owner == OWN_LEFT);

  assign busyOutLN  = !(masterMode && leftLoses);
  assign busyOutRN  = !(masterMode && rightLoses);
  assign wrInhibitL = masterMode ? leftLoses  : !busyInLN;
  assign wrInhibitR = masterMode ? rightLoses : !busyInRN;
endmodule

// File: rtl/busy_arb.sv
module busy_arb
  import busy_arb_pkg::*;
#(
  parameter int ADDR_W = 14
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              masterMode,
  input  logic              leftEn,
  input  logic [ADDR_W-1:0] leftAddr,
  input  logic              rightEn,
  input  logic [ADDR_W-1:0] rightAddr,
  input  logic              busyInLN,
  input  logic              busyInRN,
  output logic              busyOutLN,
  output logic              busyOutRN,
  output logic              wrInhibitL,
  output logic              wrInhibitR
);
  cmpStrobe_t strobe;

  busy_arb_cmp #(.ADDR_W(ADDR_W)) u_cmp (
    .clk(clk), .rstN(rstN),
    .leftEn(leftEn), .leftAddr(leftAddr),
    .rightEn(rightEn), .rightAddr(rightAddr),
    .strobe(strobe)
  );

  busy_arb_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .masterMode(masterMode), .busyInLN(busyInLN), .busyInRN(busyInRN),
    .busyOutLN(busyOutLN), .busyOutRN(busyOutRN),
    .wrInhibitL(wrInhibitL), .wrInhibitR(wrInhibitR)
  );
endmodule

// File: rtl/busy_arb_chk.sv
module busy_arb_chk #(
  parameter int ADDR_W = 14
) (
  input logic              clk,
  input logic              rstN,
  input logic              masterMode,
  input logic              leftEn,
  input logic [ADDR_W-1:0] leftAddr,
  input logic              rightEn,
  input logic [ADDR_W-1:0] rightAddr,
  input logic              busyInLN,
  input logic              busyInRN,
  input logic              busyOutLN,
  input logic              busyOutRN,
  input logic              wrInhibitL,
  input logic              wrInhibitR
);
  logic hit;
  assign hit = leftEn && rightEn && (leftAddr == rightAddr);

  a_r1_busy_needs_match: assert property (@(posedge clk) disable iff (!rstN)
    (masterMode && (!busyOutLN || !busyOutRN)) |-> $past(hit));

  a_r5_release_on_mismatch: assert property (@(posedge clk) disable iff (!rstN)
    (masterMode && !$past(hit)) |-> (busyOutLN && busyOutRN));

  a_r6_never_both_busy: assert property (@(posedge clk) disable iff (!rstN)
    !(!busyOutLN && !busyOutRN));

  a_r7_winner_held: assert property (@(posedge clk) disable iff (!rstN)
    (masterMode && $past(masterMode) && $past(rstN, 2) && $past(hit) && $past(hit, 2))
      |-> ($stable(busyOutLN) && $stable(busyOutRN)));

  a_r8_inhibit_tracks_busy: assert property (@(posedge clk) disable iff (!rstN)
    masterMode |-> ((wrInhibitL == !busyOutLN) && (wrInhibitR == !busyOutRN)));

  a_r9_slave_outputs_idle: assert property (@(posedge clk) disable iff (!rstN)
    !masterMode |-> (busyOutLN && busyOutRN));

  a_r9_slave_inhibit: assert property (@(posedge clk) disable iff (!rstN)
    !masterMode |-> ((wrInhibitL == !busyInLN) && (wrInhibitR == !busyInRN)));
endmodule

bind busy_arb busy_arb_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .masterMode(masterMode),
  .leftEn(leftEn), .leftAddr(leftAddr),
  .rightEn(rightEn), .rightAddr(rightAddr),
  .busyInLN(busyInLN), .busyInRN(busyInRN),
  .busyOutLN(busyOutLN), .busyOutRN(busyOutRN),
  .wrInhibitL(wrInhibitL), .wrInhibitR(wrInhibitR)
);

// File: tb/tb_busy_arb.sv
module tb_busy_arb;
  localparam int ADDR_W = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic masterMode = 1'b1;
  logic leftEn = 1'b0, rightEn = 1'b0;
  logic [ADDR_W-1:0] leftAddr = '0, rightAddr = '0;
  logic busyInLN = 1'b1, busyInRN = 1'b1;
  logic busyOutLN, busyOutRN, wrInhibitL, wrInhibitR;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // reference state: 0 none, 1 left holds, 2 right holds
  int mOwner = 0;
  logic mPrevLE = 0, mPrevRE = 0;
  logic [ADDR_W-1:0] mPrevLA = '0, mPrevRA = '0;

  always #5 clk = ~clk;

  busy_arb #(.ADDR_W(ADDR_W)) dut (
    .clk(clk), .rstN(rstN), .masterMode(masterMode),
    .leftEn(leftEn), .leftAddr(leftAddr),
    .rightEn(rightEn), .rightAddr(rightAddr),
    .busyInLN(busyInLN), .busyInRN(busyInRN),
    .busyOutLN(busyOutLN), .busyOutRN(busyOutRN),
    .wrInhibitL(wrInhibitL), .wrInhibitR(wrInhibitR)
  );

  function automatic logic expBusyLN();
    return !(masterMode && mOwner == 2);
  endfunction
  function automatic logic expBusyRN();
    return !(masterMode && mOwner == 1);
  endfunction
  function automatic logic expInhL();
    return masterMode ? (mOwner == 2) : !busyInLN;
  endfunction
  function automatic logic expInhR();
    return masterMode ? (mOwner == 1) : !busyInRN;
  endfunction

  task automatic chk1(string tag, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic checkAll(string tag);
    chk1(tag, "busyOutLN", busyOutLN, expBusyLN());
    chk1(tag, "busyOutRN", busyOutRN, expBusyRN());
    chk1(tag, "wrInhibitL", wrInhibitL, expInhL());
    chk1(tag, "wrInhibitR", wrInhibitR, expInhR());
    chk1("R6", "both busy", !busyOutLN && !busyOutRN, 1'b0);
  endtask

  // model of the clock edge that follows the inputs just driven
  task automatic modelStep();
    logic lF, rF, m;
    lF = leftEn && (!mPrevLE || leftAddr != mPrevLA);
    rF = rightEn && (!mPrevRE || rightAddr != mPrevRA);
    m  = leftEn && rightEn && (leftAddr == rightAddr);
    if (!m) mOwner = 0;
    else if (mOwner == 0) mOwner = (lF && !rF) ? 2 : 1;
    mPrevLE = leftEn; mPrevLA = leftAddr;
    mPrevRE = rightEn; mPrevRA = rightAddr;
  endtask

  // check results of the previous cycle, then apply new inputs
  task automatic step(string tag, logic ms, logic le, logic [ADDR_W-1:0] la,
                      logic re, logic [ADDR_W-1:0] ra, logic bl, logic br);
    @(negedge clk);
    checkAll(tag);
    masterMode = ms; leftEn = le; leftAddr = la; rightEn = re; rightAddr = ra;
    busyInLN = bl; busyInRN = br;
    modelStep();
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    checkAll("R2 reset");
    rstN = 1'b1;
    // R3: left starts first, right joins on the same word -> right busy
    step("R2", 1, 1, 3'd5, 0, 3'd0, 1, 1);
    step("R3", 1, 1, 3'd5, 1, 3'd5, 1, 1);
    step("R3 right loses", 1, 1, 3'd5, 1, 3'd5, 1, 1);
    chk1("R3", "right busy", busyOutRN, 1'b0);
    // R7: collision persists, winner unchanged
    step("R7 hold", 1, 1, 3'd5, 1, 3'd5, 1, 1);
    chk1("R7", "right still busy", busyOutRN, 1'b0);
    // R5: address change releases
    step("R7", 1, 1, 3'd5, 1, 3'd2, 1, 1);
    step("R5 release addr", 1, 0, 3'd0, 0, 3'd0, 1, 1);
    chk1("R5", "released", busyOutRN, 1'b1);
    // R3: right first, left joins -> left busy
    step("R3", 1, 0, 3'd0, 1, 3'd1, 1, 1);
    step("R3", 1, 1, 3'd1, 1, 3'd1, 1, 1);
    step("R3 left loses", 1, 1, 3'd1, 1, 3'd1, 1, 1);
    chk1("R3", "left busy", busyOutLN, 1'b0);
    chk1("R8", "left inhibit", wrInhibitL, 1'b1);
    // R5: enable drop releases
    step("R5", 1, 1, 3'd1, 0, 3'd1, 1, 1);
    step("R5 release en", 1, 0, 3'd0, 0, 3'd0, 1, 1);
    chk1("R5", "released", busyOutLN, 1'b1);
    // R4: same-cycle start -> left wins
    step("R4", 1, 1, 3'd7, 1, 3'd7, 1, 1);
    step("R4 tie", 1, 1, 3'd7, 1, 3'd7, 1, 1);
    chk1("R4", "right busy on tie", busyOutRN, 1'b0);
    chk1("R4", "left free on tie", busyOutLN, 1'b1);
    // R9: slave mode ignores own collision, follows busy inputs
    step("R9", 0, 1, 3'd7, 1, 3'd7, 0, 1);
    step("R9 slave", 0, 1, 3'd7, 1, 3'd7, 1, 0);
    chk1("R9", "busy out idle", busyOutRN, 1'b1);
    step("R9 slave", 0, 0, 3'd0, 0, 3'd0, 1, 1);
    // R1: random traffic, mostly master mode
    for (int i = 0; i < 4000; i++) begin
      logic ms, le, re;
      logic [ADDR_W-1:0] la, ra;
      ms = ($urandom % 8) != 0;
      le = ($urandom % 4) != 0;
      re = ($urandom % 4) != 0;
      la = (($urandom % 3) == 0) ? ADDR_W'($urandom) : leftAddr;
      ra = (($urandom % 3) == 0) ? ADDR_W'($urandom) : rightAddr;
      step("R1 random", ms, le, la, re, ra, 1'($urandom), 1'($urandom));
    end
    @(negedge clk);
    checkAll("R1 random");
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule